// File: doc/BRIEF.md
# Periodic and One-Shot Output-Compare Timer

This block keeps a 16-bit timebase that counts without stopping and rolls from 0xFFFF back to 0x0000. The timebase advances on prescaled ticks derived from the bus clock. Two compare channels watch the timebase. The periodic channel adds a programmable period to its own compare value on every match, so its interrupts arrive at a constant rate however late software services them. The one-shot channel raises its interrupt when the count reaches a value that software wrote, and it does not re-arm.

Software reaches the block through a byte-wide write port and read port. Reading the high byte of the count captures the low byte at the same moment, so a timestamp read in two steps is coherent. Each channel drives a sticky interrupt output and has its own clear input. The `tick_en` input gates the prescaler, which gives the system one place to pause the timebase.

Top module: `ocpt_timer`

## Requirements
- R1: After reset the count is 0x0000. The count rises by exactly one on each prescaled tick and wraps from 0xFFFF to 0x0000.
- R2: Control bits [2:0] select the tick division: a value k of 0 to 6 divides the enabled bus cycles by 2^k, and 7 also divides by 64. The reset value of the field is 4 (divide by 16). Starting from a freshly reset prescaler, N enabled cycles give a count of N >> k.
- R3: While `tick_en` is low, neither the prescaler nor the count changes.
- R4: A channel matches on the clock edge where the count steps onto a value whose high byte and low byte both equal its compare register. The interrupt output is high from the cycle after that edge.
- R5: On each periodic-channel match, its compare register becomes the old compare value plus the period register, modulo 2^16. Matches are therefore exactly one period apart, whether or not the flag was cleared in between.
- R6: A one-shot match leaves the one-shot compare register unchanged.
- R7: Interrupt flags are sticky. A high pulse on the clear input lowers the flag, but a match in the same cycle as the clear wins and the flag stays set.
- R8: A channel whose enable bit is 0 (control bit 3 for periodic, bit 4 for one-shot) neither sets its flag nor re-arms.
- R9: Reading address 1 returns count[15:8] and captures count[7:0]. A later read of address 2 returns the captured byte, even if the count has moved since.
- R10: Register addresses are: 0 control (reset 0x04), 3/4 periodic compare high/low, 5/6 period high/low, 7/8 one-shot compare high/low. All of them read back what was written, and reset clears the compare and period registers.
- R11: A write to the periodic compare register while the channel is enabled governs the next match. If the write falls on the same edge as a re-arm, the write wins and that re-arm is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Enables prescaler counting |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Read strobe; captures the low count byte on a high-byte read |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Read data for rd_addr (combinational) |
| clr_periodic | input | 1 | Clears the periodic channel flag |
| clr_oneshot | input | 1 | Clears the one-shot channel flag |
| irq_periodic | output | 1 | Periodic channel interrupt flag |
| irq_oneshot | output | 1 | One-shot channel interrupt flag |

## Verification
The bench builds the block with its default six-stage prescaler, so every division setting, including the clamped value 7, gets tried against the N >> k rule. Running most tests at divide-by-1 makes matches land on exact, countable cycles. One full 65540-tick run shows the count wrapping. A period of 0xFFF0 carries the re-arm sum past 16 bits, which shows the wraparound of the addition without waiting for the count itself to come near the top.

// File: rtl/ocpt_pkg.sv
package ocpt_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 4'd0,
    A_CNT_HI = 4'd1,
    A_CNT_LO = 4'd2,
    A_CMP1_H = 4'd3,
    A_CMP1_L = 4'd4,
    A_PER_H  = 4'd5,
    A_PER_L  = 4'd6,
    A_CMP2_H = 4'd7,
    A_CMP2_L = 4'd8
  } reg_addr_e;

  // Modular sum used by the periodic re-arm
  function automatic logic [CNT_W-1:0] wrap_add(input logic [CNT_W-1:0] a,
                                                 input logic [CNT_W-1:0] b);
    return a + b;
  endfunction

  // Both halves must agree for a match
  function automatic logic bytes_equal(input logic [CNT_W-1:0] a,
                                       input logic [CNT_W-1:0] b);
    return (a[CNT_W-1:BYTE_W] == b[CNT_W-1:BYTE_W]) &&
           (a[BYTE_W-1:0] == b[BYTE_W-1:0]);
  endfunction

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction
endpackage

// File: rtl/ocpt_prescaler.sv
module ocpt_prescaler #(
  parameter int PS_W  = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic [SEL_W-1:0] sel,
  output logic             step
);
  logic [PS_W-1:0] div_q;
  logic [PS_W-1:0] mask;

  // Low k bits all ones marks every 2^k-th enabled cycle; k saturates at PS_W
  always_comb begin
    mask = '0;
    for (int i = 0; i < PS_W; i++) begin
      if (int'(sel) > i) mask[i] = 1'b1;
    end
  end

  assign step = tick_en && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (!rst_n)       div_q <= '0;
    else if (tick_en) div_q <= div_q + 1'b1;
  end
endmodule

// File: rtl/ocpt_counter.sv
module ocpt_counter
  import ocpt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (step) cnt <= next_count(cnt);
  end
endmodule

// File: rtl/ocpt_channel.sv
module ocpt_channel
  import ocpt_pkg::*;
#(
  parameter bit REARM = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              step,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  period,
  input  logic              clr,
  output logic [CNT_W-1:0]  cmp,
  output logic              hit,
  output logic              irq
);
  logic             rearm;
  logic [CNT_W-1:0] rearm_val;

  // Match is detected on the edge where the count steps onto the compare value
  assign hit       = en && step && bytes_equal(next_count(cnt), cmp);
  assign rearm_val = wrap_add(cmp, period);

  generate
    if (REARM) begin : g_rearm
      assign rearm = hit;
    end else begin : g_oneshot
      assign rearm = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp <= '0;
    end else if (wr_hi || wr_lo) begin
      if (wr_hi) cmp[CNT_W-1:BYTE_W] <= wr_data;
      if (wr_lo) cmp[BYTE_W-1:0]     <= wr_data;
    end else if (rearm) begin
      cmp <= rearm_val;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   irq <= 1'b0;
    else if (hit) irq <= 1'b1;
    else if (clr) irq <= 1'b0;
  end
endmodule

// File: rtl/ocpt_timer.sv
module ocpt_timer
  import ocpt_pkg::*;
#(
  parameter int PS_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        wr_en,
  input  logic [3:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        rd_en,
  input  logic [3:0]  rd_addr,
  output logic [7:0]  rd_data,
  input  logic        clr_periodic,
  input  logic        clr_oneshot,
  output logic        irq_periodic,
  output logic        irq_oneshot
);
  localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(4);

  logic [SEL_W-1:0]  sel_q;
  logic              en_p, en_o;
  logic [CNT_W-1:0]  per_q;
  logic [BYTE_W-1:0] lo_snap;
  logic              step;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cmp_p, cmp_o;
  logic              hit_p, hit_o;
  logic              wr_cmp_p_h, wr_cmp_p_l, wr_cmp_o_h, wr_cmp_o_l;
  logic              cmp_p_wr;

  assign wr_cmp_p_h = wr_en && (wr_addr == A_CMP1_H);
  assign wr_cmp_p_l = wr_en && (wr_addr == A_CMP1_L);
  assign wr_cmp_o_h = wr_en && (wr_addr == A_CMP2_H);
  assign wr_cmp_o_l = wr_en && (wr_addr == A_CMP2_L);
  assign cmp_p_wr   = wr_cmp_p_h || wr_cmp_p_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= SEL_RST;
      en_p  <= 1'b0;
      en_o  <= 1'b0;
      per_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          sel_q <= wr_data[SEL_W-1:0];
          en_p  <= wr_data[3];
          en_o  <= wr_data[4];
        end
        A_PER_H: per_q[CNT_W-1:BYTE_W] <= wr_data;
        A_PER_L: per_q[BYTE_W-1:0]     <= wr_data;
        default: ;
      endcase
    end
  end

  // High-byte read captures the low byte for a coherent two-step timestamp
  always_ff @(posedge clk) begin
    if (!rst_n)                              lo_snap <= '0;
    else if (rd_en && (rd_addr == A_CNT_HI)) lo_snap <= cnt[BYTE_W-1:0];
  end

  ocpt_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .sel(sel_q), .step(step)
  );

  ocpt_counter u_cnt (.clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt));

  ocpt_channel #(.REARM(1'b1)) u_ch_periodic (
    .clk(clk), .rst_n(rst_n), .en(en_p), .step(step), .cnt(cnt),
    .wr_hi(wr_cmp_p_h), .wr_lo(wr_cmp_p_l), .wr_data(wr_data),
    .period(per_q), .clr(clr_periodic),
    .cmp(cmp_p), .hit(hit_p), .irq(irq_periodic)
  );

  ocpt_channel #(.REARM(1'b0)) u_ch_oneshot (
    .clk(clk), .rst_n(rst_n), .en(en_o), .step(step), .cnt(cnt),
    .wr_hi(wr_cmp_o_h), .wr_lo(wr_cmp_o_l), .wr_data(wr_data),
    .period(per_q), .clr(clr_oneshot),
    .cmp(cmp_o), .hit(hit_o), .irq(irq_oneshot)
  );

  always_comb begin
    case (rd_addr)
      A_CTRL:   rd_data = {3'b000, en_o, en_p, sel_q};
      A_CNT_HI: rd_data = cnt[CNT_W-1:BYTE_W];
      A_CNT_LO: rd_data = lo_snap;
      A_CMP1_H: rd_data = cmp_p[CNT_W-1:BYTE_W];
      A_CMP1_L: rd_data = cmp_p[BYTE_W-1:0];
      A_PER_H:  rd_data = per_q[CNT_W-1:BYTE_W];
      A_PER_L:  rd_data = per_q[BYTE_W-1:0];
      A_CMP2_H: rd_data = cmp_o[CNT_W-1:BYTE_W];
      A_CMP2_L: rd_data = cmp_o[BYTE_W-1:0];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/ocpt_checker.sv
module ocpt_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        step,
  input logic [15:0] cnt,
  input logic        hit_p,
  input logic        hit_o,
  input logic        en_o,
  input logic [15:0] cmp_p,
  input logic [15:0] per_q,
  input logic        cmp_p_wr,
  input logic        irq_p,
  input logic        clr_p
);
  p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> cnt == 16'($past(cnt) + 16'd1));

  p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt));

  p_rearm_sum_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_p && !cmp_p_wr) |=> cmp_p == 16'($past(cmp_p) + $past(per_q)));

  p_flag_on_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hit_p |=> irq_p);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_p && !clr_p) |=> irq_p);

  p_clear_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_p && !hit_p) |=> !irq_p);

  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_o |-> !hit_o);
endmodule

bind ocpt_timer ocpt_checker u_chk (
  .clk(clk), .rst_n(rst_n), .step(step), .cnt(cnt),
  .hit_p(hit_p), .hit_o(hit_o), .en_o(en_o),
  .cmp_p(cmp_p), .per_q(per_q), .cmp_p_wr(cmp_p_wr),
  .irq_p(irq_periodic), .clr_p(clr_periodic)
);

// File: tb/ocpt_timer_tb.sv
module ocpt_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       clr_periodic = 1'b0, clr_oneshot = 1'b0;
  logic       irq_periodic, irq_oneshot;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ocpt_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .clr_periodic(clr_periodic), .clr_oneshot(clr_oneshot),
    .irq_periodic(irq_periodic), .irq_oneshot(irq_oneshot)
  );

  // {select, enabled cycles, expected count}
  localparam logic [31:0] VEC [8] = '{
    {8'd0, 16'd37,  8'd37}, {8'd1, 16'd37,  8'd18},
    {8'd2, 16'd100, 8'd25}, {8'd3, 16'd100, 8'd12},
    {8'd4, 16'd160, 8'd10}, {8'd5, 16'd333, 8'd10},
    {8'd6, 16'd640, 8'd10}, {8'd7, 16'd640, 8'd10}
  };

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick_en = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    clr_periodic = 1'b0; clr_oneshot = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_count(output logic [15:0] c);
    logic [7:0] h, l;
    rd(4'd1, h);
    rd(4'd2, l);
    c = {h, l};
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic pulse_clr_p();
    @(negedge clk); clr_periodic = 1'b1;
    @(negedge clk); clr_periodic = 1'b0;
  endtask

  task automatic pulse_clr_o();
    @(negedge clk); clr_oneshot = 1'b1;
    @(negedge clk); clr_oneshot = 1'b0;
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] c, c2;

    // Reset state (R1, R10)
    do_reset();
    rd(4'd0, b);    check("R10 ctrl reset", b, 8'h04);
    rd_count(c);    check("R1 count reset", c, 16'h0000);
    #1 check("R7 irq_periodic reset", irq_periodic, 0);
    check("R7 irq_oneshot reset", irq_oneshot, 0);
    wr(4'd6, 8'hA5); rd(4'd6, b); check("R10 period low readback", b, 8'hA5);
    wr(4'd7, 8'h3C); rd(4'd7, b); check("R10 oneshot high readback", b, 8'h3C);

    // Prescaler table (R2)
    for (int i = 0; i < 8; i++) begin
      do_reset();
      wr(4'd0, VEC[i][31:24]);
      tick(int'(VEC[i][23:8]));
      rd_count(c);
      check($sformatf("R2 divide select %0d", VEC[i][31:24]), c, {8'h00, VEC[i][7:0]});
    end

    // Coherent read (R9) and freeze (R3)
    do_reset();
    wr(4'd0, 8'h00);
    tick(300);
    rd(4'd1, b);  check("R9 count high", b, 8'h01);
    tick(10);
    rd(4'd2, b);  check("R9 captured low", b, 8'h2C);
    rd_count(c);  check("R3 count before pause", c, 16'h0136);
    repeat (20) @(negedge clk);
    rd_count(c2); check("R3 count held with tick_en low", c2, 16'h0136);

    // Periodic re-arm (R4, R5)
    do_reset();
    wr(4'd0, 8'h08);
    wr(4'd4, 8'd10);
    wr(4'd6, 8'd7);
    tick(9);  #1 check("R4 no flag before match", irq_periodic, 0);
    tick(1);  #1 check("R4 flag after match", irq_periodic, 1);
    rd(4'd4, b); check("R5 compare advanced by period", b, 8'd17);
    pulse_clr_p(); #1 check("R7 clear lowers flag", irq_periodic, 0);
    tick(6);  #1 check("R5 no flag before next period", irq_periodic, 0);
    tick(1);  #1 check("R5 flag one period later", irq_periodic, 1);
    rd(4'd4, b); check("R5 compare second re-arm", b, 8'd24);
    tick(7);
    rd(4'd4, b); check("R5 re-arm without service", b, 8'd31);
    wr(4'd5, 8'hFF); wr(4'd6, 8'hF0);
    tick(7);
    rd(4'd3, b); check("R5 wrapped sum high", b, 8'h00);
    rd(4'd4, b); check("R5 wrapped sum low", b, 8'h0F);

    // Write while enabled (R11)
    do_reset();
    wr(4'd0, 8'h08); wr(4'd4, 8'd8); wr(4'd6, 8'd100);
    tick(3);
    wr(4'd4, 8'd4);
    tick(1); #1 check("R11 new compare used at next match", irq_periodic, 1);
    rd(4'd4, b); check("R11 re-arm from new compare", b, 8'd104);

    do_reset();
    wr(4'd0, 8'h08); wr(4'd4, 8'd2); wr(4'd6, 8'd50);
    tick(1);
    @(negedge clk);
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = 4'd4; wr_data = 8'd9;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    #1 check("R11 flag on coincident match", irq_periodic, 1);
    rd(4'd4, b); check("R11 write beats re-arm", b, 8'd9);

    // One-shot and clear priority (R6, R7)
    do_reset();
    wr(4'd0, 8'h10); wr(4'd8, 8'd5);
    tick(4); #1 check("R4 oneshot quiet before match", irq_oneshot, 0);
    @(negedge clk);
    tick_en = 1'b1; clr_oneshot = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; clr_oneshot = 1'b0;
    #1 check("R7 match beats clear", irq_oneshot, 1);
    rd(4'd8, b); check("R6 oneshot compare unchanged", b, 8'd5);
    tick(3);
    pulse_clr_o(); #1 check("R7 oneshot clear", irq_oneshot, 0);

    // Disabled channel (R8)
    do_reset();
    wr(4'd0, 8'h00); wr(4'd4, 8'd3); wr(4'd6, 8'd2); wr(4'd8, 8'd4);
    tick(5);
    #1 check("R8 disabled periodic no flag", irq_periodic, 0);
    check("R8 disabled oneshot no flag", irq_oneshot, 0);
    rd(4'd4, b); check("R8 disabled periodic no re-arm", b, 8'd3);

    // Full wrap (R1)
    do_reset();
    wr(4'd0, 8'h00);
    tick(65540);
    rd_count(c); check("R1 count wraps past 0xFFFF", c, 16'h0004);

    done = 1'b1;
    report();
  end
endmodule